// File: doc/BRIEF.md
# SPI flash user-mode transfer engine

This block is the serial datapath for a single flash chip select when the processor runs the bus by hand. A control word selects the operating mode, the data-lane width and whether the chip select is held. While the chip select is held in user mode, every byte the host pushes through the window write port is shifted out on the serial lines. Every window read request clocks one byte in from the flash. The host stalls on a valid/ready handshake until the byte has fully moved.

Software builds a flash command out of these primitives. It clears the stop bit to select the device. It pushes the opcode, then the address bytes most significant first, then any dummy bytes, all on one line. It then switches the lane width and moves the payload. Setting the stop bit again releases the device. The first byte after the chip select is asserted always travels on one line. If that byte was the enter-4-byte-address opcode when the transaction closes, a sticky flag is raised. That flag also selects the power-on read opcode offered to a boot fetcher. The serial clock enable comes from an external divider; the engine toggles the clock only on those enables and keeps it low while idle.

Top module: `sfl_user_engine`

## Requirements
- R1: The 32-bit control word resets to 0x0000_0004. A write replaces it whole, and `ctl_value` returns it from the next cycle.
- R2: `spi_cs_n` is low exactly when control bits [1:0] equal 2'b11 (user mode) and bit 2 (stop) is 0. It follows a control write one cycle later. Modes 2'b01 and 2'b10 never assert it.
- R3: While the chip select is not asserted, a window write completes in the same cycle that valid rises, and nothing is shifted. A window read completes at once and returns 0xFF.
- R4: Written bytes go out most significant bit first. With bit 30 set, 4 bits per clock go on io[3:0], with the upper bit on io[3]. Otherwise, with bit 29 set, 2 bits per clock go on io[1:0]. With neither set, 1 bit per clock goes on io[0]. Bit 30 wins when both are set.
- R5: The first byte after the chip select is asserted uses one lane, whatever bits 29 and 30 hold.
- R6: Read bytes are assembled first-received-most-significant. Single lane samples io[1], dual samples io[1:0], quad samples io[3:0], and the upper lane carries the higher bit.
- R7: Each bit group takes two `sclk_en` pulses: a rising edge, then a falling edge. The serial clock changes only on an enable pulse. Ready rises in the cycle after the last falling edge; with the enable held high, a byte that starts one cycle after valid rises completes after 1+2*beats cycles.
- R8: The serial clock is low whenever the chip select is deasserted and between bytes (mode 0).
- R9: A sticky flag `addr4_mode` is set when a transaction closes and its first written byte was 0xB7. Only reset clears it.
- R10: `boot_rd_opcode` is 0x03 while the flag is 0 and 0x13 once it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_value | output | 32 | Current control word |
| sclk_en | input | 1 | Serial clock enable from the divider |
| win_wr_valid | input | 1 | Host has a byte to send |
| win_wr_data | input | 8 | Byte to send |
| win_wr_ready | output | 1 | Write handshake completes |
| win_rd_valid | input | 1 | Host requests one received byte |
| win_rd_ready | output | 1 | Read handshake completes, data valid |
| win_rd_data | output | 8 | Received byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_io_o | output | 4 | Serial data out per lane |
| spi_io_oe | output | 4 | Output enable per lane |
| spi_io_i | input | 4 | Serial data in per lane |
| addr4_mode | output | 1 | Sticky 4-byte addressing flag |
| boot_rd_opcode | output | 8 | Power-on read opcode |

## Verification
The embedded properties assume that the control word is never rewritten while a byte is still being shifted, and that a host holds valid steady until it sees ready. Without these, a transfer in flight with a dropped chip select would break the busy-implies-selected property. The stimulus keeps within both: every control write comes only after the previous byte handshake has closed, and each request stays up until its ready. The enable pattern from the divider is left free; it is exercised both held high and at one pulse in three.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;
  localparam int BYTE_W   = 8;
  localparam int IO_W     = 4;
  localparam int CTL_W    = 32;
  localparam int STOP_BIT = 2;
  localparam int DUAL_BIT = 29;
  localparam int QUAD_BIT = 30;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  localparam logic [CTL_W-1:0]  CTL_RESET  = 32'h0000_0004;
  localparam logic [BYTE_W-1:0] OPC_ENTER4 = 8'hB7;
  localparam logic [BYTE_W-1:0] OPC_READ3  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_READ4  = 8'h13;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CMD_RD = 2'b01,
    MODE_CMD_WR = 2'b10,
    MODE_USER   = 2'b11
  } sfl_mode_e;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } sfl_lane_e;

  // quad has priority over dual
  function automatic sfl_lane_e lane_pick(input logic dual_b, input logic quad_b);
    if (quad_b) return LANE_X4;
    if (dual_b) return LANE_X2;
    return LANE_X1;
  endfunction

  // clock periods needed to move one byte at a given width
  function automatic logic [CNT_W-1:0] beats_for(input sfl_lane_e ln);
    case (ln)
      LANE_X2: return CNT_W'(BYTE_W / 2);
      LANE_X4: return CNT_W'(BYTE_W / 4);
      default: return CNT_W'(BYTE_W);
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] boot_opcode(input logic wide_addr);
    return wide_addr ? OPC_READ4 : OPC_READ3;
  endfunction
endpackage

// File: rtl/sfl_ctl_bank.sv
`timescale 1ns/1ps
module sfl_ctl_bank
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              byte_start,
  input  logic              byte_wr,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              user_active,
  output logic              first_pending,
  output sfl_lane_e         lane_cfg,
  output logic              addr4_flag
);
  logic [CTL_W-1:0]  ctl_r;
  logic              first_r;
  logic [BYTE_W-1:0] op_r;
  logic              op_seen_r;
  logic              a4_r;
  logic              next_active;
  logic              txn_end;

  assign user_active = (sfl_mode_e'(ctl_r[1:0]) == MODE_USER) && !ctl_r[STOP_BIT];
  assign next_active = (sfl_mode_e'(wdata[1:0]) == MODE_USER) && !wdata[STOP_BIT];
  assign txn_end     = user_active && wr_en && !next_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_r     <= CTL_RESET;
      first_r   <= 1'b1;
      op_r      <= '0;
      op_seen_r <= 1'b0;
      a4_r      <= 1'b0;
    end else begin
      if (wr_en) ctl_r <= wdata;
      if (!user_active)    first_r <= 1'b1;
      else if (byte_start) first_r <= 1'b0;
      if (byte_start && first_r && byte_wr) begin
        op_r      <= byte_data;
        op_seen_r <= 1'b1;
      end
      if (txn_end) begin
        op_seen_r <= 1'b0;
        if (op_seen_r && (op_r == OPC_ENTER4)) a4_r <= 1'b1;
      end
    end
  end

  assign ctl_q         = ctl_r;
  assign first_pending = first_r;
  assign lane_cfg      = lane_pick(ctl_r[DUAL_BIT], ctl_r[QUAD_BIT]);
  assign addr4_flag    = a4_r;

  // R9: the 4-byte flag never falls outside reset
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    a4_r |=> a4_r);
endmodule

// File: rtl/sfl_shift_unit.sv
`timescale 1ns/1ps
module sfl_shift_unit
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              start_wr,
  input  sfl_lane_e         start_lanes,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [IO_W-1:0]   io_in,
  output logic              busy,
  output logic              done,
  output logic              done_wr,
  output logic              sclk,
  output logic [IO_W-1:0]   io_out,
  output logic [IO_W-1:0]   io_oe,
  output logic [BYTE_W-1:0] rx_byte
);
  logic              busy_q, done_q, wr_q, sclk_q;
  sfl_lane_e         lanes_q;
  logic [BYTE_W-1:0] tx_q, rx_q, tx_next, rx_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              rise_ev, fall_ev, last_beat;

  assign rise_ev   = busy_q && tick && !sclk_q;
  assign fall_ev   = busy_q && tick &&  sclk_q;
  assign last_beat = (cnt_q == beats_for(lanes_q) - 1'b1);

  always_comb begin
    case (lanes_q)
      LANE_X2: begin
        rx_next = {rx_q[BYTE_W-3:0], io_in[1:0]};
        tx_next = tx_q << 2;
      end
      LANE_X4: begin
        rx_next = {rx_q[BYTE_W-5:0], io_in[3:0]};
        tx_next = tx_q << 4;
      end
      default: begin
        rx_next = {rx_q[BYTE_W-2:0], io_in[1]};
        tx_next = tx_q << 1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      sclk_q  <= 1'b0;
      lanes_q <= LANE_X1;
      tx_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        wr_q    <= start_wr;
        lanes_q <= start_lanes;
        tx_q    <= start_wr ? tx_byte : '0;
        rx_q    <= '0;
        cnt_q   <= '0;
        sclk_q  <= 1'b0;
      end else if (rise_ev) begin
        sclk_q <= 1'b1;
        rx_q   <= rx_next;
      end else if (fall_ev) begin
        sclk_q <= 1'b0;
        tx_q   <= tx_next;
        cnt_q  <= cnt_q + 1'b1;
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    io_out = '0;
    io_oe  = '0;
    case (lanes_q)
      LANE_X2: io_out[1:0] = tx_q[BYTE_W-1 -: 2];
      LANE_X4: io_out[3:0] = tx_q[BYTE_W-1 -: 4];
      default: io_out[0]   = tx_q[BYTE_W-1];
    endcase
    if (busy_q) begin
      if (lanes_q == LANE_X1) io_oe = IO_W'(4'b0001);
      else if (wr_q)          io_oe = (lanes_q == LANE_X2) ? IO_W'(4'b0011) : IO_W'(4'b1111);
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign done_wr = done_q && wr_q;
  assign sclk    = sclk_q;
  assign rx_byte = rx_q;

  // R7: serial clock moves only on an enable pulse
  a_r7_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk_q));
  // R8: clock rests low between bytes
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  // R7: beat counter stays inside the byte
  a_r7_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < beats_for(lanes_q)));
endmodule

// File: rtl/sfl_user_engine.sv
`timescale 1ns/1ps
module sfl_user_engine
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_value,
  input  logic              sclk_en,
  input  logic              win_wr_valid,
  input  logic [BYTE_W-1:0] win_wr_data,
  output logic              win_wr_ready,
  input  logic              win_rd_valid,
  output logic              win_rd_ready,
  output logic [BYTE_W-1:0] win_rd_data,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic [IO_W-1:0]   spi_io_o,
  output logic [IO_W-1:0]   spi_io_oe,
  input  logic [IO_W-1:0]   spi_io_i,
  output logic              addr4_mode,
  output logic [BYTE_W-1:0] boot_rd_opcode
);
  logic              user_active, first_pending;
  sfl_lane_e         lane_cfg, start_lanes;
  logic              busy, done, done_wr, byte_start;
  logic [BYTE_W-1:0] rx_byte;

  assign byte_start  = user_active && !busy && !done && (win_wr_valid || win_rd_valid);
  assign start_lanes = first_pending ? LANE_X1 : lane_cfg;

  sfl_ctl_bank u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (ctl_we),
    .wdata         (ctl_wdata),
    .byte_start    (byte_start),
    .byte_wr       (win_wr_valid),
    .byte_data     (win_wr_data),
    .ctl_q         (ctl_value),
    .user_active   (user_active),
    .first_pending (first_pending),
    .lane_cfg      (lane_cfg),
    .addr4_flag    (addr4_mode)
  );

  sfl_shift_unit u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (sclk_en),
    .start       (byte_start),
    .start_wr    (win_wr_valid),
    .start_lanes (start_lanes),
    .tx_byte     (win_wr_data),
    .io_in       (spi_io_i),
    .busy        (busy),
    .done        (done),
    .done_wr     (done_wr),
    .sclk        (spi_sclk),
    .io_out      (spi_io_o),
    .io_oe       (spi_io_oe),
    .rx_byte     (rx_byte)
  );

  assign spi_cs_n       = !user_active;
  assign win_wr_ready   = !user_active || done_wr;
  assign win_rd_ready   = !user_active || (done && !done_wr);
  assign win_rd_data    = user_active ? rx_byte : '1;
  assign boot_rd_opcode = boot_opcode(addr4_mode);

  // R8: no clock while deselected
  a_r8_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R3: shifting happens only inside a selected transaction
  a_r3_busy_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);
  // R5: the opcode byte goes out on one lane
  a_r5_opcode_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(first_pending)) |-> (spi_io_oe == IO_W'(4'b0001)));
  // R7: a selected write is acknowledged only after its shifting ended
  a_r7_ready_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_ready && !spi_cs_n) |-> $past(busy));
endmodule

// File: tb/sfl_user_engine_tb_top.sv
`timescale 1ns/1ps
module sfl_user_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_value;
  logic        sclk_en;
  logic        win_wr_valid = 1'b0;
  logic [7:0]  win_wr_data = '0;
  logic        win_wr_ready;
  logic        win_rd_valid = 1'b0;
  logic        win_rd_ready;
  logic [7:0]  win_rd_data;
  logic        spi_cs_n, spi_sclk;
  logic [3:0]  spi_io_o, spi_io_oe, spi_io_i;
  logic        addr4_mode;
  logic [7:0]  boot_rd_opcode;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  int tick_div = 1, tick_cnt = 0;

  // flash model state
  int         slave_lanes = 1;
  logic [7:0] cap = '0;
  int         cap_bits = 0;
  logic [7:0] resp = '0;
  int         resp_idx = 0;
  int         sclk_rises = 0;
  logic       exp_cs_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
  assign sclk_en = (tick_cnt == 0);

  sfl_user_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_value(ctl_value),
    .sclk_en(sclk_en), .win_wr_valid(win_wr_valid), .win_wr_data(win_wr_data),
    .win_wr_ready(win_wr_ready), .win_rd_valid(win_rd_valid), .win_rd_ready(win_rd_ready),
    .win_rd_data(win_rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_io_o(spi_io_o),
    .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i), .addr4_mode(addr4_mode),
    .boot_rd_opcode(boot_rd_opcode)
  );

  // flash drives the next bits of its response, most significant first
  always @* begin
    logic [7:0] sh;
    sh = resp << resp_idx;
    if (slave_lanes == 4)      spi_io_i = sh[7:4];
    else if (slave_lanes == 2) spi_io_i = {2'b00, sh[7:6]};
    else                       spi_io_i = {2'b00, sh[7], 1'b0};
  end

  // flash captures on rising serial clock
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (slave_lanes == 4)      cap = {cap[3:0], spi_io_o[3:0]};
      else if (slave_lanes == 2) cap = {cap[5:0], spi_io_o[1:0]};
      else                       cap = {cap[6:0], spi_io_o[0]};
      cap_bits   += slave_lanes;
      resp_idx   += slave_lanes;
      sclk_rises += 1;
    end
  end

  // per-clock comparison against the bench's own select model (R2, R8)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      tests++;
      if (spi_cs_n !== exp_cs_n) begin
        fails++;
        $display("FAIL R2 cs_n act=%0b exp=%0b at %0t", spi_cs_n, exp_cs_n, $time);
      end
      if (spi_cs_n && spi_sclk) begin
        fails++;
        $display("FAIL R8 sclk act=1 exp=0 while deselected at %0t", $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(posedge clk);
    #1 exp_cs_n = !((v[1:0] == 2'b11) && !v[2]);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input int lanes, output int cycles);
    slave_lanes = lanes;
    cap = '0;
    cap_bits = 0;
    @(negedge clk);
    win_wr_valid = 1'b1;
    win_wr_data = b;
    #1 cycles = 0;
    while (!win_wr_ready) begin
      @(negedge clk);
      #1 cycles++;
    end
    @(negedge clk);
    win_wr_valid = 1'b0;
  endtask

  task automatic get_byte(input logic [7:0] r, input int lanes, output logic [7:0] d, output int cycles);
    slave_lanes = lanes;
    resp = r;
    resp_idx = 0;
    @(negedge clk);
    win_rd_valid = 1'b1;
    #1 cycles = 0;
    while (!win_rd_ready) begin
      @(negedge clk);
      #1 cycles++;
    end
    d = win_rd_data;
    @(negedge clk);
    win_rd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    int rises0;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 reset ctl", ctl_value, 32'h4);
    check("R2 reset cs_n", spi_cs_n, 1);
    check("R8 reset sclk", spi_sclk, 0);
    check("R9 reset flag", addr4_mode, 0);
    check("R10 reset opcode", boot_rd_opcode, 8'h03);

    // mode off: window ignored
    rises0 = sclk_rises;
    put_byte(8'h5A, 1, cyc);
    check("R3 write ignored ready", cyc, 0);
    check("R3 write ignored no clock", sclk_rises - rises0, 0);
    get_byte(8'h00, 1, d, cyc);
    check("R3 read idle value", d, 8'hFF);
    check("R3 read idle ready", cyc, 0);

    // user mode but stopped; command-read mode with stop clear
    ctl_write(32'h0000_0007);
    check("R1 readback", ctl_value, 32'h7);
    check("R2 stopped cs_n", spi_cs_n, 1);
    ctl_write(32'h0000_0001);
    check("R2 cmd-read cs_n", spi_cs_n, 1);
    rises0 = sclk_rises;
    put_byte(8'hC3, 1, cyc);
    check("R3 cmd-read write ignored", sclk_rises - rises0, 0);

    // select with quad preset: opcode must still use one lane
    ctl_write(32'h4000_0003);
    check("R2 selected cs_n", spi_cs_n, 0);
    check("R1 readback quad", ctl_value, 32'h4000_0003);
    put_byte(8'h9F, 1, cyc);
    check("R5 opcode single lane", cap, 8'h9F);
    check("R5 opcode bit count", cap_bits, 8);
    check("R7 single byte cycles", cyc, 17);

    // address bytes, single lane, MSB first
    ctl_write(32'h0000_0003);
    put_byte(8'h12, 1, cyc);
    check("R4 addr byte 0", cap, 8'h12);
    put_byte(8'h34, 1, cyc);
    check("R4 addr byte 1", cap, 8'h34);

    // dual data
    ctl_write(32'h2000_0003);
    put_byte(8'hA5, 2, cyc);
    check("R4 dual write", cap, 8'hA5);
    check("R7 dual cycles", cyc, 9);

    // quad data
    ctl_write(32'h4000_0003);
    put_byte(8'h3C, 4, cyc);
    check("R4 quad write", cap, 8'h3C);
    check("R7 quad cycles", cyc, 5);

    // both width bits: quad wins
    ctl_write(32'h6000_0003);
    put_byte(8'hE1, 4, cyc);
    check("R4 both bits quad", cap, 8'hE1);

    // reads at each width
    get_byte(8'hC7, 4, d, cyc);
    check("R6 quad read", d, 8'hC7);
    ctl_write(32'h2000_0003);
    get_byte(8'h5A, 2, d, cyc);
    check("R6 dual read", d, 8'h5A);
    ctl_write(32'h0000_0003);
    get_byte(8'h81, 1, d, cyc);
    check("R6 single read", d, 8'h81);
    check("R7 single read cycles", cyc, 17);

    // close a non-0xB7 transaction
    ctl_write(32'h0000_0007);
    check("R9 flag after other opcode", addr4_mode, 0);
    check("R10 opcode still 3-byte", boot_rd_opcode, 8'h03);

    // enter-4-byte transaction, dual preset, opcode single
    ctl_write(32'h2000_0003);
    put_byte(8'hB7, 1, cyc);
    check("R5 B7 single lane", cap, 8'hB7);
    check("R9 flag not before close", addr4_mode, 0);
    ctl_write(32'h0000_0007);
    check("R9 flag set on close", addr4_mode, 1);
    check("R10 opcode 4-byte", boot_rd_opcode, 8'h13);

    // slow enable: one pulse in three
    tick_div = 3;
    ctl_write(32'h0000_0003);
    put_byte(8'h66, 1, cyc);
    check("R7 slow enable write", cap, 8'h66);
    check("R7 slow enable bits", cap_bits, 8);
    put_byte(8'h0F, 1, cyc);
    check("R7 slow enable second byte", cap, 8'h0F);
    ctl_write(32'h0000_0007);
    check("R9 flag sticky", addr4_mode, 1);
    tick_div = 1;

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule